// File: doc/BRIEF.md
# VS-Level Interrupt Register Routing Unit

This block keeps the registers through which a hypervisor injects and filters interrupts for a guest running in VS mode on a 64-bit hart. It stores five things: the per-bit virtual enable vector, the hypervisor's own pending bits for local interrupts, the machine pending store that the VS software, timer and external bits share, the machine enable store, and a separate guest enable store. The block exposes one read-modify-write CSR port. Each access returns the value held before the access. In the same clock edge, the block commits `(old & ~mask) | (wdata & mask)` to every bit that the access is allowed to change.

The guest sees its pending and enable registers through per-bit routing. The delegation vector `hideleg` arrives as an input, and `hvien` is held inside the block. Together they decide where each guest-visible bit comes from: the machine stores, the hypervisor-owned stores, or a constant zero. The three VS-level bits move down one position on the way to the guest, and the local bits (13 and above) keep their position. The block ANDs the routed pending view with the routed enable view and drives the result as the VS interrupt vector. This lets the hypervisor raise a guest interrupt that has no physical source at all.

The block has no state machine. Each access completes in one cycle, and the routing is purely combinational.

Top module: `vsint_alias_unit`

## Requirements
- R1: On an access to a known address, `csr_rdata` shows the register value before the access, and at the next rising clock edge each permitted bit becomes `(old & ~wmask) | (wdata & wmask)`.
- R2: Address 0x608 (virtual enable) has bits 63:13 writable, and bits 12:0 always read as zero.
- R3: Address 0x618 (virtual enable, upper half) returns enable bits 63:32 in `csr_rdata[31:0]` with zero above them. A write to it uses `wdata[31:0]` and `wmask[31:0]` to update enable bits 63:32 only.
- R4: Address 0x645 (hypervisor pending) has writable bits 2, 6, 10 and 63:13, and all other bits read as zero. Bits 2, 6 and 10 are the machine pending store itself, not a copy of it.
- R5: At address 0x244 (guest pending), bits 1, 5 and 9 read as machine pending bits 2, 6 and 10 when the matching `hideleg` bit is set, and read as zero otherwise. Bits 0, 2-4, 6-8 and 10-12 always read as zero.
- R6: Through address 0x244, bit 1 can be written only when `hideleg[2]` is set. Bits 5 and 9 are read-only.
- R7: For each bit i of 13..63 at address 0x244: if `hideleg[i]` is set, the bit is the machine pending bit i. Otherwise, if enable bit i is set, it is hypervisor pending bit i. Otherwise it reads as zero and ignores writes.
- R8: At address 0x204 (guest enable), bits 1, 5 and 9 are machine enable bits 2, 6 and 10 when the matching `hideleg` bit is set. Otherwise they read as zero and ignore writes.
- R9: For each bit i of 13..63 at address 0x204: if `hideleg[i]` is set, the bit is machine enable bit i. Otherwise, if enable bit i is set, it is bit i of the separate guest enable store. Otherwise it reads as zero and ignores writes.
- R10: `vs_pend` equals the guest pending view ANDed with the guest enable view, in guest bit positions. It follows a state change at the next edge and a `hideleg` change in the same cycle. A hypervisor pending bit with enable set and delegation clear raises it with no hardware source.
- R11: An access to any other address drives `csr_illegal` high and `csr_rdata` to zero, and changes no state.
- R12: After reset all stores are zero, so every register reads as zero and `vs_pend` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| csr_valid | input | 1 | Access strobe for this cycle |
| csr_addr | input | 12 | Register address |
| csr_wdata | input | 64 | Write data |
| csr_wmask | input | 64 | Per-bit write mask; zero makes a pure read |
| csr_rdata | output | 64 | Value before the access |
| csr_illegal | output | 1 | Access to an unknown address |
| hideleg | input | 64 | Per-bit delegation vector |
| vs_pend | output | 64 | VS-level pending and enabled interrupts, guest positions |

## Verification
A wrong route code or a misplaced shift shows up on the very next read of the guest pending or enable address. It also shows up on `vs_pend` in the same cycle that `hideleg` or `hvien` selects the faulty bit. A write that reaches the wrong store stays hidden until a later delegation change moves that bit's route to the other store. For this reason the stimulus changes `hideleg` often between accesses, and it compares every read and every cycle's `vs_pend` with a bit-level model.

// File: rtl/vsint_pkg.sv
package vsint_pkg;
    localparam int XLEN = 64;
    // Guest-level software, timer and external bits in hypervisor positions
    localparam logic [XLEN-1:0] VS_BITS    = 64'h0000_0000_0000_0444;
    // Local interrupt bits 13 and above
    localparam logic [XLEN-1:0] LOCAL_BITS = 64'hFFFF_FFFF_FFFF_E000;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_HVIEN,
        SEL_HVIENH,
        SEL_HVIP,
        SEL_VSIP,
        SEL_VSIE
    } csr_sel_e;

    typedef enum logic [1:0] {
        RT_ZERO,
        RT_MACH,
        RT_HYP
    } route_e;
endpackage

// File: rtl/vsint_csr_decode.sv
module vsint_csr_decode
    import vsint_pkg::*;
#(
    parameter int          AW       = 12,
    parameter logic [11:0] A_HVIEN  = 12'h608,
    parameter logic [11:0] A_HVIENH = 12'h618,
    parameter logic [11:0] A_HVIP   = 12'h645,
    parameter logic [11:0] A_VSIP   = 12'h244,
    parameter logic [11:0] A_VSIE   = 12'h204
) (
    input  logic          valid,
    input  logic [AW-1:0] addr,
    output csr_sel_e      sel,
    output logic          illegal
);
    always_comb begin
        sel = SEL_NONE;
        if (valid) begin
            unique case (addr)
                A_HVIEN:  sel = SEL_HVIEN;
                A_HVIENH: sel = SEL_HVIENH;
                A_HVIP:   sel = SEL_HVIP;
                A_VSIP:   sel = SEL_VSIP;
                A_VSIE:   sel = SEL_VSIE;
                default:  sel = SEL_NONE;
            endcase
        end
        illegal = valid && (sel == SEL_NONE);
    end
endmodule

// File: rtl/vsint_mreg.sv
module vsint_mreg #(
    parameter int           W    = 64,
    parameter logic [W-1:0] IMPL = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] wm,
    input  logic [W-1:0] wd,
    output logic [W-1:0] q
);
    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= ((q & ~wm) | (wd & wm)) & IMPL;
    end

    // R1
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wm == '0) |=> $stable(q));
endmodule

// File: rtl/vsint_bit_route.sv
module vsint_bit_route
    import vsint_pkg::*;
(
    input  logic [XLEN-1:0] hideleg,
    input  logic [XLEN-1:0] hvien,
    input  logic [XLEN-1:0] mip,
    input  logic [XLEN-1:0] mie,
    input  logic [XLEN-1:0] hvip,
    input  logic [XLEN-1:0] vsie_st,
    input  logic [XLEN-1:0] wdata,
    input  logic [XLEN-1:0] wmask,
    output logic [XLEN-1:0] vsip_view,
    output logic [XLEN-1:0] vsie_view,
    output logic [XLEN-1:0] wd_st,
    output logic [XLEN-1:0] mip_wm,
    output logic [XLEN-1:0] hvip_wm,
    output logic [XLEN-1:0] mie_wm,
    output logic [XLEN-1:0] vst_wm
);
    // Storage index k drives guest view index VIEW (k-1 for VS bits)
    for (genvar k = 0; k < XLEN; k++) begin : g_st
        localparam bit LIVE = VS_BITS[k] | LOCAL_BITS[k];
        localparam bit ISVS = VS_BITS[k];
        localparam int VIEW = ISVS ? k - 1 : k;
        localparam bit RO   = (k == 6) || (k == 10);
        if (LIVE) begin : g_live
            route_e rt;
            always_comb begin
                if (hideleg[k])           rt = RT_MACH;
                else if (!ISVS && hvien[k]) rt = RT_HYP;
                else                      rt = RT_ZERO;
            end
            assign vsip_view[VIEW] = ((rt == RT_MACH) && mip[k]) ||
                                     ((rt == RT_HYP)  && hvip[k]);
            assign vsie_view[VIEW] = ((rt == RT_MACH) && mie[k]) ||
                                     ((rt == RT_HYP)  && vsie_st[k]);
            assign wd_st[k]   = wdata[VIEW];
            assign mip_wm[k]  = wmask[VIEW] && (rt == RT_MACH) && !RO;
            assign hvip_wm[k] = wmask[VIEW] && (rt == RT_HYP);
            assign mie_wm[k]  = wmask[VIEW] && (rt == RT_MACH);
            assign vst_wm[k]  = wmask[VIEW] && (rt == RT_HYP);
        end else begin : g_dead
            assign wd_st[k]   = 1'b0;
            assign mip_wm[k]  = 1'b0;
            assign hvip_wm[k] = 1'b0;
            assign mie_wm[k]  = 1'b0;
            assign vst_wm[k]  = 1'b0;
        end
    end

    for (genvar j = 0; j < XLEN; j++) begin : g_view
        localparam bit VLIVE = VS_BITS[(j + 1) % XLEN] | LOCAL_BITS[j];
        if (!VLIVE) begin : g_zero
            assign vsip_view[j] = 1'b0;
            assign vsie_view[j] = 1'b0;
        end
    end

    logic unused_route_bits;
    assign unused_route_bits = ^{hideleg, hvien, mip, mie, hvip, vsie_st, wdata, wmask};
endmodule

// File: rtl/vsint_alias_unit.sv
module vsint_alias_unit
    import vsint_pkg::*;
#(
    parameter int          AW       = 12,
    parameter logic [11:0] A_HVIEN  = 12'h608,
    parameter logic [11:0] A_HVIENH = 12'h618,
    parameter logic [11:0] A_HVIP   = 12'h645,
    parameter logic [11:0] A_VSIP   = 12'h244,
    parameter logic [11:0] A_VSIE   = 12'h204
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            csr_valid,
    input  logic [AW-1:0]   csr_addr,
    input  logic [XLEN-1:0] csr_wdata,
    input  logic [XLEN-1:0] csr_wmask,
    output logic [XLEN-1:0] csr_rdata,
    output logic            csr_illegal,
    input  logic [XLEN-1:0] hideleg,
    output logic [XLEN-1:0] vs_pend
);
    localparam int HALF = XLEN / 2;

    csr_sel_e        sel;
    logic [XLEN-1:0] hvien_q, hvip_q, mip_q, mie_q, vst_q;
    logic [XLEN-1:0] hvien_wm, hvien_wd, hvip_wm, hvip_wd, mip_wm, mip_wd;
    logic [XLEN-1:0] mie_wm, vst_wm;
    logic [XLEN-1:0] vsip_view, vsie_view, r_wd;
    logic [XLEN-1:0] r_mip_wm, r_hvip_wm, r_mie_wm, r_vst_wm;

    vsint_csr_decode #(
        .AW(AW), .A_HVIEN(A_HVIEN), .A_HVIENH(A_HVIENH),
        .A_HVIP(A_HVIP), .A_VSIP(A_VSIP), .A_VSIE(A_VSIE)
    ) u_dec (
        .valid   (csr_valid),
        .addr    (csr_addr),
        .sel     (sel),
        .illegal (csr_illegal)
    );

    vsint_bit_route u_route (
        .hideleg   (hideleg),
        .hvien     (hvien_q),
        .mip       (mip_q),
        .mie       (mie_q),
        .hvip      (hvip_q),
        .vsie_st   (vst_q),
        .wdata     (csr_wdata),
        .wmask     (csr_wmask),
        .vsip_view (vsip_view),
        .vsie_view (vsie_view),
        .wd_st     (r_wd),
        .mip_wm    (r_mip_wm),
        .hvip_wm   (r_hvip_wm),
        .mie_wm    (r_mie_wm),
        .vst_wm    (r_vst_wm)
    );

    // Per-store write selection
    always_comb begin
        hvien_wm = '0;
        hvien_wd = csr_wdata;
        hvip_wm  = '0;
        hvip_wd  = csr_wdata;
        mip_wm   = '0;
        mip_wd   = csr_wdata;
        mie_wm   = '0;
        vst_wm   = '0;
        unique case (sel)
            SEL_HVIEN: hvien_wm = csr_wmask;
            SEL_HVIENH: begin
                hvien_wm = {csr_wmask[HALF-1:0], {HALF{1'b0}}};
                hvien_wd = {csr_wdata[HALF-1:0], {HALF{1'b0}}};
            end
            SEL_HVIP: begin
                hvip_wm = csr_wmask & LOCAL_BITS;
                mip_wm  = csr_wmask & VS_BITS;
            end
            SEL_VSIP: begin
                hvip_wm = r_hvip_wm;
                hvip_wd = r_wd;
                mip_wm  = r_mip_wm;
                mip_wd  = r_wd;
            end
            SEL_VSIE: begin
                mie_wm = r_mie_wm;
                vst_wm = r_vst_wm;
            end
            default: ;
        endcase
    end

    vsint_mreg #(.W(XLEN), .IMPL(LOCAL_BITS)) u_hvien (
        .clk(clk), .rst_n(rst_n), .wm(hvien_wm), .wd(hvien_wd), .q(hvien_q));
    vsint_mreg #(.W(XLEN), .IMPL(LOCAL_BITS)) u_hvip (
        .clk(clk), .rst_n(rst_n), .wm(hvip_wm), .wd(hvip_wd), .q(hvip_q));
    vsint_mreg #(.W(XLEN), .IMPL(VS_BITS | LOCAL_BITS)) u_mip (
        .clk(clk), .rst_n(rst_n), .wm(mip_wm), .wd(mip_wd), .q(mip_q));
    vsint_mreg #(.W(XLEN), .IMPL(VS_BITS | LOCAL_BITS)) u_mie (
        .clk(clk), .rst_n(rst_n), .wm(mie_wm), .wd(r_wd), .q(mie_q));
    vsint_mreg #(.W(XLEN), .IMPL(LOCAL_BITS)) u_vst (
        .clk(clk), .rst_n(rst_n), .wm(vst_wm), .wd(r_wd), .q(vst_q));

    // Old-value read mux
    always_comb begin
        unique case (sel)
            SEL_HVIEN:  csr_rdata = hvien_q;
            SEL_HVIENH: csr_rdata = {{HALF{1'b0}}, hvien_q[XLEN-1:HALF]};
            SEL_HVIP:   csr_rdata = (mip_q & VS_BITS) | (hvip_q & LOCAL_BITS);
            SEL_VSIP:   csr_rdata = vsip_view;
            SEL_VSIE:   csr_rdata = vsie_view;
            default:    csr_rdata = '0;
        endcase
    end

    assign vs_pend = vsip_view & vsie_view;

    // R11
    illegal_rdata_chk: assert property (@(posedge clk) disable iff (!rst_n)
        csr_illegal |-> (csr_rdata == '0));
    // R11
    illegal_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        csr_illegal |=> ($stable(hvien_q) && $stable(hvip_q) && $stable(mip_q)
                         && $stable(mie_q) && $stable(vst_q)));
    // R6
    vsip_ro_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sel == SEL_VSIP) |=> ($stable(mip_q[6]) && $stable(mip_q[10])));
    // R3
    hvienh_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sel == SEL_HVIENH) |=> $stable(hvien_q[HALF-1:0]));
    // R10
    pend_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((vs_pend & LOCAL_BITS & ~(hideleg | hvien_q)) == '0));
    // R8
    vsie_ungated_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((sel == SEL_VSIE) && !hideleg[2]) |=> $stable(mie_q[2]));
endmodule

// File: tb/sim_vsint_alias_unit.sv
module sim_vsint_alias_unit;
    localparam logic [63:0] LOC = 64'hFFFF_FFFF_FFFF_E000;
    localparam logic [11:0] AD_HVIEN = 12'h608, AD_HVIENH = 12'h618,
                            AD_HVIP = 12'h645, AD_VSIP = 12'h244, AD_VSIE = 12'h204;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        csr_valid = 1'b0;
    logic [11:0] csr_addr = '0;
    logic [63:0] csr_wdata = '0, csr_wmask = '0, hideleg = '0;
    logic [63:0] csr_rdata, vs_pend;
    logic        csr_illegal;

    int checks = 0, fails = 0;
    bit done = 1'b0;
    logic [63:0] m_hl = '0, m_hv = '0, m_hvip = '0, m_mip = '0, m_mie = '0, m_vst = '0;

    always #2 clk = ~clk;

    vsint_alias_unit u0 (
        .clk(clk), .rst_n(rst_n), .csr_valid(csr_valid), .csr_addr(csr_addr),
        .csr_wdata(csr_wdata), .csr_wmask(csr_wmask), .csr_rdata(csr_rdata),
        .csr_illegal(csr_illegal), .hideleg(hideleg), .vs_pend(vs_pend));

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [63:0] exp_vsip();
        logic [63:0] r = '0;
        for (int j = 0; j < 64; j++) begin
            if (j == 1 || j == 5 || j == 9) r[j] = m_hl[j+1] & m_mip[j+1];
            else if (j >= 13) r[j] = m_hl[j] ? m_mip[j] : (m_hv[j] & m_hvip[j]);
        end
        return r;
    endfunction

    function automatic logic [63:0] exp_vsie();
        logic [63:0] r = '0;
        for (int j = 0; j < 64; j++) begin
            if (j == 1 || j == 5 || j == 9) r[j] = m_hl[j+1] & m_mie[j+1];
            else if (j >= 13) r[j] = m_hl[j] ? m_mie[j] : (m_hv[j] & m_vst[j]);
        end
        return r;
    endfunction

    function automatic logic [63:0] exp_read(input logic [11:0] a);
        case (a)
            AD_HVIEN:  return m_hv;
            AD_HVIENH: return {32'h0, m_hv[63:32]};
            AD_HVIP:   return (m_mip & 64'h444) | (m_hvip & LOC);
            AD_VSIP:   return exp_vsip();
            AD_VSIE:   return exp_vsie();
            default:   return 64'h0;
        endcase
    endfunction

    function automatic bit known(input logic [11:0] a);
        return a == AD_HVIEN || a == AD_HVIENH || a == AD_HVIP || a == AD_VSIP || a == AD_VSIE;
    endfunction

    task automatic model_write(input logic [11:0] a, input logic [63:0] d, input logic [63:0] m);
        for (int i = 0; i < 64; i++) begin
            if (m[i]) begin
                case (a)
                    AD_HVIEN: if (i >= 13) m_hv[i] = d[i];
                    AD_HVIENH: if (i < 32) m_hv[i+32] = d[i];
                    AD_HVIP: begin
                        if (i == 2 || i == 6 || i == 10) m_mip[i] = d[i];
                        else if (i >= 13) m_hvip[i] = d[i];
                    end
                    AD_VSIP: begin
                        if (i == 1 && m_hl[2]) m_mip[2] = d[1];
                        else if (i >= 13) begin
                            if (m_hl[i]) m_mip[i] = d[i];
                            else if (m_hv[i]) m_hvip[i] = d[i];
                        end
                    end
                    AD_VSIE: begin
                        if ((i == 1 || i == 5 || i == 9) && m_hl[i+1]) m_mie[i+1] = d[i];
                        else if (i >= 13) begin
                            if (m_hl[i]) m_mie[i] = d[i];
                            else if (m_hv[i]) m_vst[i] = d[i];
                        end
                    end
                    default: ;
                endcase
            end
        end
    endtask

    task automatic acc(input logic [11:0] a, input logic [63:0] d, input logic [63:0] m,
                       input string tag);
        @(negedge clk);
        csr_valid = 1'b1; csr_addr = a; csr_wdata = d; csr_wmask = m;
        #1;
        chk(tag, csr_rdata, exp_read(a));
        chk(known(a) ? tag : "R11", {63'h0, csr_illegal}, {63'h0, !known(a)});
        @(posedge clk);
        model_write(a, d, m);
        #1;
        csr_valid = 1'b0; csr_wmask = '0;
        chk("R10", vs_pend, exp_vsip() & exp_vsie());
    endtask

    task automatic set_hl(input logic [63:0] v);
        @(negedge clk);
        hideleg = v; m_hl = v;
        #1;
        chk("R10", vs_pend, exp_vsip() & exp_vsie());
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", checks, 0);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [63:0] rd;
        void'($urandom(32'd2024));
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        #1 chk("R12", vs_pend, 64'h0);
        acc(AD_HVIEN, 0, 0, "R12");
        acc(AD_HVIENH, 0, 0, "R12");
        acc(AD_HVIP, 0, 0, "R12");
        acc(AD_VSIP, 0, 0, "R12");
        acc(AD_VSIE, 0, 0, "R12");
        // R2: all ones, low bits stay zero
        acc(AD_HVIEN, '1, '1, "R2");
        @(negedge clk); csr_valid = 1; csr_addr = AD_HVIEN; csr_wmask = 0; #1;
        chk("R2", csr_rdata, LOC); rd = csr_rdata;
        @(posedge clk); #1 csr_valid = 0;
        // R3: upper half write
        acc(AD_HVIENH, 64'hFFFF_FFFF_A5A5_0000, 64'h0000_0000_FFFF_FFFF, "R3");
        acc(AD_HVIEN, 0, 0, "R3");
        chk("R3", m_hv, 64'hA5A5_0000_FFFF_E000);
        acc(AD_HVIEN, '1, LOC, "R2");
        // R1: masked update with old-value return
        acc(AD_HVIP, 64'h0000_0000_0010_0000, 64'h0000_0000_0030_0000, "R1");
        @(negedge clk); csr_valid = 1; csr_addr = AD_HVIP; csr_wdata = 0; csr_wmask = 64'h0000_0000_0020_0000; #1;
        chk("R1", csr_rdata, 64'h0000_0000_0010_0000);
        @(posedge clk); model_write(AD_HVIP, 0, 64'h0000_0000_0020_0000); #1 csr_valid = 0;
        // R10: virtual interrupt with no physical source on bit 20
        set_hl(64'h0);
        acc(AD_VSIE, 64'h0000_0000_0010_0000, 64'h0000_0000_0010_0000, "R9");
        chk("R10", vs_pend, 64'h0000_0000_0010_0000);
        // R7: local bit routed to zero when enable cleared
        acc(AD_HVIEN, 0, 64'h0000_0000_0010_0000, "R7");
        acc(AD_VSIP, 0, 0, "R7");
        chk("R10", vs_pend, 64'h0);
        // R6: bits 5 and 9 read-only through guest pending
        set_hl('1);
        acc(AD_HVIP, 64'h446, 64'h446, "R4");
        acc(AD_VSIP, 0, 64'h0000_0000_0000_0222, "R6");
        acc(AD_VSIP, 0, 0, "R6");
        chk("R6", m_mip & 64'h444, 64'h440);
        acc(AD_VSIP, 0, 0, "R5");
        // R5: undelegated VS bits read zero
        set_hl(64'h0);
        acc(AD_VSIP, 0, 0, "R5");
        // R8: guest enable VS bits ignored when not delegated
        acc(AD_VSIE, '1, 64'h222, "R8");
        set_hl(64'h444);
        acc(AD_VSIE, 0, 0, "R8");
        acc(AD_VSIE, 64'h222, 64'h222, "R8");
        acc(AD_VSIE, 0, 0, "R8");
        // R11: unknown address
        acc(12'h123, '1, '1, "R11");
        acc(AD_HVIEN, 0, 0, "R11");
        acc(AD_HVIP, 0, 0, "R11");
        acc(AD_VSIE, 0, 0, "R11");
        // Random mix
        for (int n = 0; n < 600; n++) begin
            int r;
            logic [11:0] a;
            logic [63:0] d, m;
            string tag;
            if (n % 7 == 0) set_hl({$urandom, $urandom});
            r = $urandom % 6;
            case (r)
                0: begin a = AD_HVIEN;  tag = "R2"; end
                1: begin a = AD_HVIENH; tag = "R3"; end
                2: begin a = AD_HVIP;   tag = "R4"; end
                3: begin a = AD_VSIP;   tag = "R7"; end
                4: begin a = AD_VSIE;   tag = "R9"; end
                default: begin a = 12'h100 + 12'($urandom % 16); tag = "R11"; end
            endcase
            d = {$urandom, $urandom};
            m = ($urandom % 2) ? '1 : {$urandom, $urandom};
            acc(a, d, m, tag);
        end
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule